// File: doc/BRIEF.md
# Doorbell Memory Operation Engine

This block carries out memory-to-memory work that firmware hands it through a pair of ring queues held in the same local memory that it operates on. Firmware writes a four-word command into the next free submission slot and then rings the submission doorbell with the new producer index. The engine reads the command and carries out the operation one 32-bit word at a time. It then writes a one-word completion entry into the completion ring. Firmware polls a non-empty flag and consumes entries by ringing the completion doorbell with its new consumer index.

Six operations are provided: copy, fill with a constant, compare, and three bitwise combines of two sources (XOR, XNOR, OR). Compare writes nothing to memory and stops at the first differing word. It reports that word's offset in the completion entry. The ring base addresses and depths come from configuration inputs, and both rings wrap inside the block. A ring of depth N holds at most N-1 pending entries.

The control is a single state machine. S_IDLE waits for the submission ring to be non-empty and then goes to S_FETCH. S_FETCH issues four reads and goes to S_FTAIL, which captures the last word. S_DECODE sends a bad opcode or a zero length straight to S_POST. It sends a fill to S_WR and all other operations to S_RDA. S_RDA reads source A. A copy goes next to S_WR; a two-source operation goes to S_RDB, which reads source B, and then to S_EXEC. S_EXEC writes the combined word, or compares the two words and leaves for S_POST on a mismatch. S_WR writes a copied or fill word. S_EXEC and S_WR return to S_RDA (or repeat S_WR for a fill) until the last word. They then go to S_POST. S_POST waits while the completion ring is full, and otherwise writes the entry and returns to S_IDLE.

Top module: `dbme_engine`

## Requirements
- R1: After reset, sq_head and cq_tail are 0, cq_not_empty is 0 and no memory request is made.
- R2: While the submission doorbell index differs from sq_head, the engine fetches the command at word address cfg_sq_base + 4*sq_head. Word 0 holds the opcode in bits [7:0] and the tag in bits [15:8]. Word 1 holds source A in bits [15:0]. Word 2 holds the source B word address, or the fill value, in all 32 bits. Word 3 holds the destination in bits [31:16] and the length in words in bits [15:0].
- R3: Opcode 1 (copy) writes dst+i with the word at A+i for i from 0 to length-1 and writes no other word.
- R4: Opcode 2 (fill) writes the word 2 value to dst+i for i from 0 to length-1 and writes no other word.
- R5: Opcode 3 (compare) with equal regions completes with status 0 and offset 0 and writes no data word.
- R6: A compare with a difference completes with status 1 and an offset equal to the lowest i where A+i and B+i differ.
- R7: Opcodes 4, 5 and 6 write A^B, ~(A^B) and A|B per word to dst+i for i from 0 to length-1.
- R8: Any other opcode (including 0) completes with status 2 and offset 0 and changes no data word.
- R9: A length of 0 with a valid opcode completes with status 0 and changes no data word.
- R10: The completion entry is {tag[7:0], 6'b0, status[1:0], offset[15:0]}, written at cfg_cq_base + cq_tail. cq_not_empty is 1 exactly while cq_tail differs from the consumer index written by the completion doorbell.
- R11: When advancing cq_tail would make it equal the consumer index, the engine holds the completion unposted and sq_head unchanged until the consumer index moves.
- R12: sq_head and cq_tail advance by one per posted completion and wrap from depth-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_sq_base | input | AW | Submission ring base word address |
| cfg_sq_depth | input | PW | Submission ring depth in entries (at least 2) |
| cfg_cq_base | input | AW | Completion ring base word address |
| cfg_cq_depth | input | PW | Completion ring depth in entries (at least 2) |
| sq_db_we | input | 1 | Submission doorbell write strobe |
| sq_db_tail | input | PW | New submission producer index |
| cq_db_we | input | 1 | Completion doorbell write strobe |
| cq_db_head | input | PW | New completion consumer index |
| sq_head | output | PW | Submission consumer index |
| cq_tail | output | PW | Completion producer index |
| cq_not_empty | output | 1 | Completion ring holds unread entries |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |

## Verification
A state machine that takes a wrong branch shows up within one command as a wrong status, a wrong offset or an altered guard word just past the destination. A stuck loop shows up as a completion that never arrives. A wrong word counter or wrong fetch capture corrupts the next destination write, and the bench's per-word comparison against its own model catches it. Pointer faults surface at sq_head and cq_tail within one posted entry, and ring-full faults surface as the fourth of four quick commands posting too early.

// File: rtl/dbme_pkg.sv
package dbme_pkg;

    localparam logic [7:0] OPC_COPY = 8'd1;
    localparam logic [7:0] OPC_FILL = 8'd2;
    localparam logic [7:0] OPC_CMP  = 8'd3;
    localparam logic [7:0] OPC_XOR  = 8'd4;
    localparam logic [7:0] OPC_XNOR = 8'd5;
    localparam logic [7:0] OPC_OR   = 8'd6;

    localparam logic [1:0] CST_OK   = 2'd0;
    localparam logic [1:0] CST_MISS = 2'd1;
    localparam logic [1:0] CST_BAD  = 2'd2;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FETCH,
        S_FTAIL,
        S_DECODE,
        S_RDA,
        S_RDB,
        S_EXEC,
        S_WR,
        S_POST
    } dbme_state_e;

endpackage

// File: rtl/dbme_ring.sv
module dbme_ring #(
    parameter int PW       = 4,
    parameter bit EXT_PROD = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] depth,
    input  logic          ext_we,
    input  logic [PW-1:0] ext_val,
    input  logic          int_adv,
    output logic [PW-1:0] int_ptr,
    output logic          empty,
    output logic          full
);

    logic [PW-1:0] int_q;
    logic [PW-1:0] ext_q;
    logic [PW-1:0] int_nxt;
    logic [PW-1:0] prod;
    logic [PW-1:0] cons;
    logic [PW-1:0] prod_nxt;

    assign int_nxt = (int_q == depth - 1'b1) ? '0 : int_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_q <= '0;
            ext_q <= '0;
        end else begin
            if (ext_we)
                ext_q <= ext_val;
            if (int_adv)
                int_q <= int_nxt;
        end
    end

    assign prod     = EXT_PROD ? ext_q : int_q;
    assign cons     = EXT_PROD ? int_q : ext_q;
    assign prod_nxt = (prod == depth - 1'b1) ? '0 : prod + 1'b1;
    assign empty    = (prod == cons);
    assign full     = (prod_nxt == cons);
    assign int_ptr  = int_q;

    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int_q < depth); // R12

    generate
        if (EXT_PROD) begin : g_consumer
            AST_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
                int_adv |-> !empty); // R2
        end else begin : g_producer
            AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
                int_adv |-> !full); // R11
        end
    endgenerate

endmodule

// File: rtl/dbme_alu.sv
module dbme_alu
    import dbme_pkg::*;
(
    input  logic [7:0]  op,
    input  logic [31:0] a,
    input  logic [31:0] b,
    output logic [31:0] res,
    output logic        differ
);

    always_comb begin
        case (op)
            OPC_XOR:  res = a ^ b;
            OPC_XNOR: res = ~(a ^ b);
            OPC_OR:   res = a | b;
            default:  res = a;
        endcase
    end

    assign differ = (a != b);

endmodule

// File: rtl/dbme_engine.sv
module dbme_engine
    import dbme_pkg::*;
#(
    parameter int AW = 16,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cfg_sq_base,
    input  logic [PW-1:0] cfg_sq_depth,
    input  logic [AW-1:0] cfg_cq_base,
    input  logic [PW-1:0] cfg_cq_depth,
    input  logic          sq_db_we,
    input  logic [PW-1:0] sq_db_tail,
    input  logic          cq_db_we,
    input  logic [PW-1:0] cq_db_head,
    output logic [PW-1:0] sq_head,
    output logic [PW-1:0] cq_tail,
    output logic          cq_not_empty,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata
);

    localparam int LW = 16;

    dbme_state_e state_q, state_d;

    logic [1:0]    fcnt_q;
    logic [7:0]    op_q;
    logic [7:0]    tag_q;
    logic [AW-1:0] srca_q;
    logic [31:0]   srcb_q;
    logic [AW-1:0] dst_q;
    logic [LW-1:0] len_q;
    logic [LW-1:0] idx_q;
    logic [31:0]   a_q;
    logic [1:0]    st_q;
    logic [LW-1:0] off_q;

    logic sq_empty, sq_full_unused, cq_empty, cq_full;
    logic sq_adv, cq_adv;
    logic op_valid, two_src, is_cmp, last_w;
    logic cap_en;
    logic [1:0] cap_idx;
    logic [31:0] alu_res;
    logic alu_diff;

    dbme_ring #(.PW(PW), .EXT_PROD(1'b1)) u_sq (
        .clk     (clk),
        .rst_n   (rst_n),
        .depth   (cfg_sq_depth),
        .ext_we  (sq_db_we),
        .ext_val (sq_db_tail),
        .int_adv (sq_adv),
        .int_ptr (sq_head),
        .empty   (sq_empty),
        .full    (sq_full_unused)
    );

    dbme_ring #(.PW(PW), .EXT_PROD(1'b0)) u_cq (
        .clk     (clk),
        .rst_n   (rst_n),
        .depth   (cfg_cq_depth),
        .ext_we  (cq_db_we),
        .ext_val (cq_db_head),
        .int_adv (cq_adv),
        .int_ptr (cq_tail),
        .empty   (cq_empty),
        .full    (cq_full)
    );

    dbme_alu u_alu (
        .op     (op_q),
        .a      (a_q),
        .b      (mem_rdata),
        .res    (alu_res),
        .differ (alu_diff)
    );

    assign cq_not_empty = !cq_empty;

    assign op_valid = (op_q >= OPC_COPY) && (op_q <= OPC_OR);
    assign is_cmp   = (op_q == OPC_CMP);
    assign two_src  = is_cmp || (op_q == OPC_XOR) || (op_q == OPC_XNOR) || (op_q == OPC_OR);
    assign last_w   = (idx_q == len_q - 1'b1);

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (!sq_empty) state_d = S_FETCH;
            S_FETCH:  if (fcnt_q == 2'd3) state_d = S_FTAIL;
            S_FTAIL:  state_d = S_DECODE;
            S_DECODE: begin
                if (!op_valid || len_q == '0) state_d = S_POST;
                else if (op_q == OPC_FILL)    state_d = S_WR;
                else                          state_d = S_RDA;
            end
            S_RDA:    state_d = two_src ? S_RDB : S_WR;
            S_RDB:    state_d = S_EXEC;
            S_EXEC: begin
                if ((is_cmp && alu_diff) || last_w) state_d = S_POST;
                else                                state_d = S_RDA;
            end
            S_WR: begin
                if (last_w)                state_d = S_POST;
                else if (op_q == OPC_FILL) state_d = S_WR;
                else                       state_d = S_RDA;
            end
            S_POST:   if (!cq_full) state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Command capture and word loop registers
    assign cap_en  = (state_q == S_FTAIL) || ((state_q == S_FETCH) && (fcnt_q != 2'd0));
    assign cap_idx = (state_q == S_FTAIL) ? 2'd3 : fcnt_q - 2'd1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fcnt_q <= '0;
            op_q   <= '0;
            tag_q  <= '0;
            srca_q <= '0;
            srcb_q <= '0;
            dst_q  <= '0;
            len_q  <= '0;
            idx_q  <= '0;
            a_q    <= '0;
            st_q   <= CST_OK;
            off_q  <= '0;
        end else begin
            if (state_q == S_IDLE)
                fcnt_q <= '0;
            else if (state_q == S_FETCH)
                fcnt_q <= fcnt_q + 2'd1;

            if (cap_en) begin
                case (cap_idx)
                    2'd0: begin
                        op_q  <= mem_rdata[7:0];
                        tag_q <= mem_rdata[15:8];
                    end
                    2'd1: srca_q <= mem_rdata[AW-1:0];
                    2'd2: srcb_q <= mem_rdata;
                    default: begin
                        dst_q <= mem_rdata[16+AW-1:16];
                        len_q <= mem_rdata[15:0];
                    end
                endcase
            end

            if (state_q == S_DECODE) begin
                idx_q <= '0;
                off_q <= '0;
                st_q  <= op_valid ? CST_OK : CST_BAD;
            end

            if (state_q == S_RDB)
                a_q <= mem_rdata;

            if (state_q == S_EXEC && is_cmp && alu_diff) begin
                st_q  <= CST_MISS;
                off_q <= idx_q;
            end

            if ((state_q == S_EXEC || state_q == S_WR) && state_d != S_POST)
                idx_q <= idx_q + 1'b1;
        end
    end

    // Outputs per state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        sq_adv    = 1'b0;
        cq_adv    = 1'b0;
        unique case (state_q)
            S_IDLE, S_FTAIL, S_DECODE: begin
            end
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = cfg_sq_base + AW'({sq_head, 2'b00}) + AW'(fcnt_q);
            end
            S_RDA: begin
                mem_req  = 1'b1;
                mem_addr = srca_q + AW'(idx_q);
            end
            S_RDB: begin
                mem_req  = 1'b1;
                mem_addr = srcb_q[AW-1:0] + AW'(idx_q);
            end
            S_EXEC: begin
                if (!is_cmp) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = dst_q + AW'(idx_q);
                    mem_wdata = alu_res;
                end
            end
            S_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_q + AW'(idx_q);
                mem_wdata = (op_q == OPC_FILL) ? srcb_q : mem_rdata;
            end
            S_POST: begin
                if (!cq_full) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = cfg_cq_base + AW'(cq_tail);
                    mem_wdata = {tag_q, 6'b0, st_q, off_q};
                    sq_adv    = 1'b1;
                    cq_adv    = 1'b1;
                end
            end
            default: begin
            end
        endcase
    end

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmp && (state_q == S_RDA || state_q == S_RDB || state_q == S_EXEC)) |-> !mem_we); // R5

    AST_MISS_OFFSET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_POST && st_q == CST_MISS) |-> (off_q < len_q)); // R6

    AST_HOLD_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_POST && cq_full) |=> (state_q == S_POST && $stable(sq_head))); // R11

    AST_BAD_OP_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DECODE && !op_valid) |=> (state_q == S_POST && st_q == CST_BAD)); // R8

endmodule

// File: tb/dbme_engine_bench.sv
module dbme_engine_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW  = 12;
    localparam int PW  = 4;
    localparam int SQB = 'h000;
    localparam int SQD = 8;
    localparam int CQB = 'h040;
    localparam int CQD = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sq_db_we = 1'b0;
    logic [PW-1:0] sq_db_tail = '0;
    logic          cq_db_we = 1'b0;
    logic [PW-1:0] cq_db_head = '0;
    logic [PW-1:0] sq_head;
    logic [PW-1:0] cq_tail;
    logic          cq_not_empty;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;

    logic [31:0] mem [0:(1<<AW)-1];

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    int sw_tail = 0;
    int sw_head = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbme_engine #(.AW(AW), .PW(PW)) u_dbme_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_sq_base  (AW'(SQB)),
        .cfg_sq_depth (PW'(SQD)),
        .cfg_cq_base  (AW'(CQB)),
        .cfg_cq_depth (PW'(CQD)),
        .sq_db_we     (sq_db_we),
        .sq_db_tail   (sq_db_tail),
        .cq_db_we     (cq_db_we),
        .cq_db_head   (cq_db_head),
        .sq_head      (sq_head),
        .cq_tail      (cq_tail),
        .cq_not_empty (cq_not_empty),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired: act=%0d cycles exp=<150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: act=%08h exp=%08h", rq, what, act, exp);
        end
    endtask

    function automatic bit valid_op(input logic [7:0] op);
        return (op >= 8'd1) && (op <= 8'd6);
    endfunction

    function automatic logic [31:0] model_word(input logic [7:0] op, input logic [31:0] x,
                                               input logic [31:0] y, input logic [31:0] fv);
        case (op)
            8'd1:    return x;
            8'd2:    return fv;
            8'd4:    return x ^ y;
            8'd5:    return ~(x ^ y);
            8'd6:    return x | y;
            default: return 32'h0;
        endcase
    endfunction

    task automatic push_cmd(input logic [7:0] op, input logic [7:0] tag, input int a,
                            input logic [31:0] bv, input int d, input int len);
        int base;
        base = SQB + sw_tail * 4;
        mem[base]     = {16'h0, tag, op};
        mem[base + 1] = {20'h0, a[11:0]};
        mem[base + 2] = bv;
        mem[base + 3] = {4'h0, d[11:0], len[15:0]};
        sw_tail = (sw_tail + 1) % SQD;
        @(negedge clk);
        sq_db_we   = 1'b1;
        sq_db_tail = PW'(sw_tail);
        @(negedge clk);
        sq_db_we   = 1'b0;
    endtask

    task automatic pop_cq(output logic [31:0] ent);
        int t;
        t = 0;
        while (!cq_not_empty && t < 3000) begin
            @(negedge clk);
            t++;
        end
        if (!cq_not_empty) begin
            chk(1'b0, "R2", "completion timeout", 32'(t), 32'd3000);
            ent = 32'hxxxxxxxx;
            return;
        end
        ent = mem[CQB + sw_head];
        sw_head = (sw_head + 1) % CQD;
        cq_db_we   = 1'b1;
        cq_db_head = PW'(sw_head);
        @(negedge clk);
        cq_db_we   = 1'b0;
    endtask

    task automatic run_cmd(input logic [7:0] op, input logic [7:0] tag, input int a,
                           input logic [31:0] bv, input int d, input int len, input string rq);
        logic [31:0] exp_d [0:16];
        logic [31:0] ent;
        int est, eoff, bad;
        est = 0;
        eoff = 0;
        for (int i = 0; i <= len; i++) exp_d[i] = mem[d + i];
        if (!valid_op(op)) begin
            est = 2;
        end else begin
            for (int i = 0; i < len; i++) begin
                if (op == 8'd3) begin
                    if (est == 0 && mem[a + i] != mem[int'(bv[11:0]) + i]) begin
                        est = 1;
                        eoff = i;
                    end
                end else begin
                    exp_d[i] = model_word(op, mem[a + i], mem[int'(bv[11:0]) + i], bv);
                end
            end
        end
        push_cmd(op, tag, a, bv, d, len);
        pop_cq(ent);
        chk(ent === {tag, 6'b0, 2'(est), 16'(eoff)}, rq, "completion entry",
            ent, {tag, 6'b0, 2'(est), 16'(eoff)});
        bad = 0;
        for (int i = 0; i <= len; i++) if (mem[d + i] !== exp_d[i]) bad++;
        chk(bad == 0, rq, "destination words wrong (incl. guard)", 32'(bad), 32'd0);
    endtask

    initial begin
        logic [31:0] ent;
        int sqh0, cqh0, a, b, d, len, pick;
        logic [7:0] op;
        void'($urandom(32'd2024));
        for (int i = 0; i < (1 << AW); i++) mem[i] = $urandom;
        for (int i = 0; i < SQD * 4; i++) mem[SQB + i] = 32'h0;

        repeat (4) @(negedge clk);
        chk(sq_head == 0 && cq_tail == 0, "R1", "pointers in reset", {sq_head, cq_tail}, 0);
        chk(!cq_not_empty && !mem_req, "R1", "flags in reset", {cq_not_empty, mem_req}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!mem_req && !cq_not_empty, "R1", "idle after reset", {cq_not_empty, mem_req}, 0);

        // Directed operations
        run_cmd(8'd1, 8'h11, 'h100, 32'h0, 'h600, 5, "R3");
        chk(!cq_not_empty, "R10", "empty after consume", 32'(cq_not_empty), 0);
        run_cmd(8'd2, 8'h12, 'h0, 32'hDEADBEEF, 'h620, 3, "R4");
        for (int i = 0; i < 4; i++) mem['h340 + i] = mem['h140 + i];
        run_cmd(8'd3, 8'h13, 'h140, 32'h340, 'h640, 4, "R5");
        for (int i = 0; i < 6; i++) mem['h360 + i] = mem['h160 + i];
        mem['h362] = ~mem['h162];
        mem['h364] = ~mem['h164];
        run_cmd(8'd3, 8'h14, 'h160, 32'h360, 'h660, 6, "R6");
        mem['h370] = ~mem['h170];
        run_cmd(8'd3, 8'h15, 'h170, 32'h370, 'h670, 3, "R6");
        for (int i = 0; i < 5; i++) mem['h380 + i] = mem['h180 + i];
        mem['h384] = mem['h184] ^ 32'h1;
        run_cmd(8'd3, 8'h16, 'h180, 32'h380, 'h680, 5, "R6");
        run_cmd(8'd4, 8'h17, 'h1A0, 32'h3A0, 'h6A0, 4, "R7");
        run_cmd(8'd5, 8'h18, 'h1B0, 32'h3B0, 'h6B0, 4, "R7");
        run_cmd(8'd6, 8'h19, 'h1C0, 32'h3C0, 'h6C0, 4, "R7");
        run_cmd(8'd0, 8'h1A, 'h1D0, 32'h3D0, 'h6D0, 4, "R8");
        run_cmd(8'd9, 8'h1B, 'h1D0, 32'h3D0, 'h6D0, 4, "R8");
        run_cmd(8'd1, 8'h1C, 'h1E0, 32'h0, 'h6E0, 0, "R9");

        // Ring-full stall: 4 commands into a depth-4 completion ring
        sqh0 = sw_tail;
        cqh0 = sw_head;
        for (int k = 0; k < 4; k++)
            push_cmd(8'd2, 8'hA0 + 8'(k), 0, 32'h5000 + k, 'h700 + k, 1);
        repeat (80) @(negedge clk);
        chk(cq_tail == PW'((cqh0 + 3) % CQD), "R11", "cq_tail while full",
            32'(cq_tail), 32'((cqh0 + 3) % CQD));
        chk(sq_head == PW'((sqh0 + 3) % SQD), "R11", "sq_head held while full",
            32'(sq_head), 32'((sqh0 + 3) % SQD));
        for (int k = 0; k < 4; k++) begin
            pop_cq(ent);
            chk(ent[31:24] == 8'hA0 + 8'(k), "R11", "tag order after stall",
                {24'h0, ent[31:24]}, 32'hA0 + k);
        end
        chk(mem['h703] == 32'h5003, "R11", "stalled command executed", mem['h703], 32'h5003);

        // Random mix
        for (int n = 0; n < 40; n++) begin
            pick = $urandom_range(0, 5);
            op   = 8'(pick + 1);
            len  = $urandom_range(1, 12);
            a    = 'h100 + $urandom_range(0, 'hF0);
            b    = 'h300 + $urandom_range(0, 'hF0);
            d    = 'h600 + $urandom_range(0, 'hF0);
            if (op == 8'd3) begin
                for (int i = 0; i < len; i++) mem[b + i] = mem[a + i];
                if ($urandom_range(0, 1) == 1) mem[b + $urandom_range(0, len - 1)] ^= 32'h80;
            end
            if (op == 8'd2) run_cmd(op, 8'(n), a, $urandom, d, len, "R7");
            else            run_cmd(op, 8'(n), a, 32'(b), d, len, "R7");
        end
        chk(sq_head == PW'(sw_tail), "R12", "sq_head after wraps", 32'(sq_head), 32'(sw_tail));
        chk(cq_tail == PW'(sw_head), "R12", "cq_tail after wraps", 32'(cq_tail), 32'(sw_head));
        chk(!cq_not_empty, "R10", "empty at end", 32'(cq_not_empty), 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule